// File: doc/BRIEF.md
# Inactivity Power-Down Timer Unit

This block watches activity signals in a processor system and steps the system through three progressively deeper low-power stages: doze, stand-by and suspend. Each stage has its own inactivity timeout. When a timeout runs out, the block enters the next stage and raises a system-management interrupt request. Any system activity returns the block to the full-on stage at once and raises a wake request. A housekeeping timer lets short bursts of background work happen during doze or stand-by without waking the system. A separate peripheral timer reports when the peripherals have gone idle.

For each stage the block produces a periodic clock-stop waveform whose high and low lengths can be programmed. It also drives a set of power-plane enables, and planes chosen by a mask are switched off while the system is suspended. Software writes the timeouts, duty settings and plane mask through a simple write port. It reads the interrupt cause from the status output and clears it by writing ones to the status address.

Top module: `pm_idle_unit`

## Requirements
- R1: After synchronous reset the stage is full-on (code 0), the status is zero, smi_req is low, every plane enable is high and stop_clk_n is high.
- R2: In full-on, with no system activity, the stage becomes doze (code 1) exactly doze_timeout+1 cycles after the last reload, and status bit 0 is set at that edge.
- R3: Doze moves to stand-by (code 2) after stby_timeout+1 cycles, setting status bit 1. Stand-by moves to suspend (code 3) after susp_timeout+1 cycles, setting status bit 2. Each timer starts only when the previous stage has ended.
- R4: A system activity pulse reloads the power-down timer, so pulses spaced closer than the doze timeout keep the block in full-on.
- R5: System activity in doze, stand-by or suspend returns the stage to full-on on the next edge and sets status bit 3.
- R6: A housekeeping pulse in doze or stand-by loads the housekeeping timer. While that timer runs, the stage timer holds, the stage does not change and status bit 3 is not set. In full-on a housekeeping pulse has no effect on the doze timing.
- R7: The peripheral timer reloads on peripheral activity. periph_idle rises periph_timeout cycles after the last pulse, and status bit 4 is set one cycle later.
- R8: smi_req is high exactly when a status bit is set. Writing to address 5 clears each status bit whose data bit is 1 and leaves the other bits unchanged.
- R9: stop_clk_n is high for on ticks and low for off ticks in each period, one tick being TICK_DIV cycles. The on count is in data bits [7:0] and the off count in bits [15:8] of addresses 6 to 9, for full-on, doze, stand-by and suspend in that order. An off count of 0 holds the output high. An on count of 0 with a nonzero off count holds it low.
- R10: In suspend, each plane enable whose bit in the mask at address 10 is 1 is low, and the other enables are high. Outside suspend all plane enables are high.
- R11: Timeout registers are at addresses 0 (doze), 1 (stand-by), 2 (suspend), 3 (housekeeping) and 4 (peripheral). A new value takes effect at the next reload of that timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_act | input | 1 | System activity event |
| hk_act | input | 1 | Housekeeping activity event |
| periph_act | input | 1 | Peripheral activity event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CNT_W | Register write data |
| pm_state | output | 2 | Current stage code |
| smi_req | output | 1 | Interrupt request to the processor |
| smi_status | output | 5 | Interrupt cause bits |
| stop_clk_n | output | 1 | Clock-stop modulation, low requests stop |
| plane_en | output | NPLANE | Power-plane enables |
| periph_idle | output | 1 | Peripheral inactivity flag |

## Verification
The assertions check on every cycle that stages only advance one step at a time or return to full-on, that activity always forces full-on on the next edge and flags a wake, that a running housekeeping timer stops a doze stage from advancing, that status bits fall only under a clearing write, and that a rising peripheral idle flag is recorded. Only the bench scenarios can show the exact timeout lengths of each stage, that reloads keep the block awake, the measured duty of the clock-stop waveform and its constant cases, and the masked plane pattern in suspend.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    typedef enum logic [1:0] {
        PM_FULL = 2'd0,
        PM_DOZE = 2'd1,
        PM_STBY = 2'd2,
        PM_SUSP = 2'd3
    } pm_state_e;

    localparam int REG_AW  = 4;
    localparam int DUTY_W  = 8;
    localparam int NSTAT   = 5;
    localparam int NTIMERS = 5;
    localparam int NSTAGES = 4;

    localparam logic [REG_AW-1:0] A_DOZE   = 4'd0;
    localparam logic [REG_AW-1:0] A_STBY   = 4'd1;
    localparam logic [REG_AW-1:0] A_SUSP   = 4'd2;
    localparam logic [REG_AW-1:0] A_HK     = 4'd3;
    localparam logic [REG_AW-1:0] A_PERIPH = 4'd4;
    localparam logic [REG_AW-1:0] A_STAT   = 4'd5;
    localparam logic [REG_AW-1:0] A_DUTY0  = 4'd6;
    localparam logic [REG_AW-1:0] A_MASK   = 4'd10;

    localparam int S_DOZE = 0;
    localparam int S_STBY = 1;
    localparam int S_SUSP = 2;
    localparam int S_WAKE = 3;
    localparam int S_PERI = 4;

    typedef struct packed {
        logic [DUTY_W-1:0] off_len;
        logic [DUTY_W-1:0] on_len;
    } duty_t;

    function automatic pm_state_e deeper(pm_state_e s);
        return pm_state_e'(s + 2'd1);
    endfunction
endpackage

// File: rtl/pm_downcnt.sv
module pm_downcnt #(
    parameter int W = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= RST_VAL;
        else if (load)               cnt <= load_val;
        else if (en && cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pm_clkmod.sv
module pm_clkmod #(
    parameter int DIV    = 4,
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [DUTY_W-1:0] on_len,
    input  logic [DUTY_W-1:0] off_len,
    output logic              run_o
);
    localparam int DW = $clog2(DIV + 1);

    logic [DW-1:0]     div_cnt;
    logic              tick;
    logic              ph_on;
    logic [DUTY_W-1:0] pcnt;
    logic [DUTY_W:0]   len_cur;
    logic [DUTY_W:0]   pcnt_nx;

    assign tick    = (div_cnt == DW'(DIV - 1));
    assign len_cur = {1'b0, (ph_on ? on_len : off_len)};
    assign pcnt_nx = {1'b0, pcnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || tick) div_cnt <= '0;
        else             div_cnt <= div_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ph_on <= 1'b1;
            pcnt  <= '0;
        end else if (tick) begin
            if (pcnt_nx >= len_cur) begin
                ph_on <= ~ph_on;
                pcnt  <= '0;
            end else begin
                pcnt  <= pcnt_nx[DUTY_W-1:0];
            end
        end
    end

    always_comb begin
        if (off_len == '0)     run_o = 1'b1;
        else if (on_len == '0) run_o = 1'b0;
        else                   run_o = ph_on;
    end
endmodule

// File: rtl/pm_idle_unit.sv
module pm_idle_unit
    import pmu_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int TICK_DIV   = 4,
    parameter int NPLANE     = 4,
    parameter int DEF_DOZE   = 200,
    parameter int DEF_STBY   = 400,
    parameter int DEF_SUSP   = 800,
    parameter int DEF_HK     = 16,
    parameter int DEF_PERIPH = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_act,
    input  logic              hk_act,
    input  logic              periph_act,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [1:0]        pm_state,
    output logic              smi_req,
    output logic [4:0]        smi_status,
    output logic              stop_clk_n,
    output logic [NPLANE-1:0] plane_en
    ,output logic             periph_idle
);
    localparam logic [CNT_W-1:0] RV_DOZE = CNT_W'(DEF_DOZE);
    localparam logic [CNT_W-1:0] RV_PERI = CNT_W'(DEF_PERIPH);

    pm_state_e         state, state_n;
    logic [CNT_W-1:0]  to_q [NTIMERS];
    duty_t             duty_q [NSTAGES];
    logic [NPLANE-1:0] mask_q;
    logic [NSTAT-1:0]  stat, stat_set, stat_clr;

    logic hk_zone, hold, stage_zero, stage_exp, stage_load, hk_zero;
    logic p_zero, p_zero_q;
    logic [CNT_W-1:0] stage_val;
    duty_t duty_cur;

    // register write port
    always_ff @(posedge clk) begin
        if (rst) begin
            to_q[0] <= RV_DOZE;
            to_q[1] <= CNT_W'(DEF_STBY);
            to_q[2] <= CNT_W'(DEF_SUSP);
            to_q[3] <= CNT_W'(DEF_HK);
            to_q[4] <= RV_PERI;
            for (int i = 0; i < NSTAGES; i++) duty_q[i] <= '{off_len: '0, on_len: DUTY_W'(1)};
            mask_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NTIMERS; i++)
                if (wr_addr == REG_AW'(i)) to_q[i] <= wr_data;
            for (int i = 0; i < NSTAGES; i++)
                if (wr_addr == A_DUTY0 + REG_AW'(i)) duty_q[i] <= duty_t'(wr_data[2*DUTY_W-1:0]);
            if (wr_addr == A_MASK) mask_q <= wr_data[NPLANE-1:0];
        end
    end

    // stage sequencing
    assign hk_zone    = (state == PM_DOZE) || (state == PM_STBY);
    assign hold       = hk_zone && (hk_act || !hk_zero);
    assign stage_exp  = (state != PM_SUSP) && stage_zero && !sys_act && !hold;
    assign stage_load = sys_act || stage_exp;

    always_comb begin
        if (sys_act)                stage_val = to_q[0];
        else if (state == PM_FULL)  stage_val = to_q[1];
        else if (state == PM_DOZE)  stage_val = to_q[2];
        else                        stage_val = '0;
    end

    always_comb begin
        state_n = state;
        if (sys_act)        state_n = PM_FULL;
        else if (stage_exp) state_n = deeper(state);
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PM_FULL;
        else     state <= state_n;
    end

    pm_downcnt #(.W(CNT_W), .RST_VAL(RV_DOZE)) u_stage (
        .clk(clk), .rst(rst), .load(stage_load), .load_val(stage_val),
        .en(!hold && state != PM_SUSP), .zero(stage_zero));

    pm_downcnt #(.W(CNT_W), .RST_VAL('0)) u_hk (
        .clk(clk), .rst(rst), .load(hk_zone && hk_act && !sys_act),
        .load_val(to_q[3]), .en(1'b1), .zero(hk_zero));

    pm_downcnt #(.W(CNT_W), .RST_VAL(RV_PERI)) u_peri (
        .clk(clk), .rst(rst), .load(periph_act), .load_val(to_q[4]),
        .en(1'b1), .zero(p_zero));

    always_ff @(posedge clk) begin
        if (rst) p_zero_q <= 1'b0;
        else     p_zero_q <= p_zero;
    end

    // interrupt status, write-one-to-clear, new causes win
    always_comb begin
        stat_set         = '0;
        stat_set[S_DOZE] = stage_exp && (state == PM_FULL);
        stat_set[S_STBY] = stage_exp && (state == PM_DOZE);
        stat_set[S_SUSP] = stage_exp && (state == PM_STBY);
        stat_set[S_WAKE] = sys_act && (state != PM_FULL);
        stat_set[S_PERI] = p_zero && !p_zero_q;
        stat_clr = (wr_en && wr_addr == A_STAT) ? wr_data[NSTAT-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= (stat & ~stat_clr) | stat_set;
    end

    // clock-stop modulation per stage
    assign duty_cur = duty_q[state];

    pm_clkmod #(.DIV(TICK_DIV), .DUTY_W(DUTY_W)) u_mod (
        .clk(clk), .rst(rst), .restart(state_n != state),
        .on_len(duty_cur.on_len), .off_len(duty_cur.off_len), .run_o(stop_clk_n));

    assign plane_en    = (state == PM_SUSP) ? ~mask_q : '1;
    assign pm_state    = state;
    assign smi_status  = stat;
    assign smi_req     = |stat;
    assign periph_idle = p_zero;

    // R3
    stage_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state != PM_FULL && state != $past(state)) |-> ($past(pm_state) + 2'd1 == pm_state));
    // R5
    wake_full_chk: assert property (@(posedge clk) disable iff (rst)
        sys_act |=> (state == PM_FULL));
    // R5
    wake_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (sys_act && state != PM_FULL) |=> smi_status[S_WAKE]);
    // R6
    hk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PM_DOZE && !hk_zero && !sys_act) |=> (state == PM_DOZE));
    // R8
    w1c_only_chk: assert property (@(posedge clk) disable iff (rst)
        (|($past(stat) & ~stat)) |-> $past(wr_en && wr_addr == A_STAT));
    // R7
    peri_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(periph_idle) |=> smi_status[S_PERI]);
endmodule

// File: tb/tb_pm_idle_unit.sv
module tb_pm_idle_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sys_act = 1'b0, hk_act = 1'b0, periph_act = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  pm_state;
    logic        smi_req;
    logic [4:0]  smi_status;
    logic        stop_clk_n;
    logic [3:0]  plane_en;
    logic        periph_idle;

    int total = 0;
    int bad   = 0;

    localparam int T_D = 10, T_S = 8, T_U = 6, T_H = 5, DIVT = 4;

    always #10 clk = ~clk;

    pm_idle_unit dut (
        .clk(clk), .rst(rst), .sys_act(sys_act), .hk_act(hk_act),
        .periph_act(periph_act), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pm_state(pm_state), .smi_req(smi_req),
        .smi_status(smi_status), .stop_clk_n(stop_clk_n),
        .plane_en(plane_en), .periph_idle(periph_idle));

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_sys();
        sys_act = 1'b1; step(1); sys_act = 1'b0;
    endtask

    task automatic pulse_hk();
        hk_act = 1'b1; step(1); hk_act = 1'b0;
    endtask

    task automatic count_high(int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (stop_clk_n) hi++;
            step(1);
        end
    endtask

    task automatic t_reset();
        check("R1 state", int'(pm_state), 0);
        check("R1 status", int'(smi_status), 0);
        check("R1 smi", int'(smi_req), 0);
        check("R1 planes", int'(plane_en), 15);
        check("R1 stop_clk_n", int'(stop_clk_n), 1);
    endtask

    task automatic t_setup();
        wr(4, 60000);
        periph_act = 1'b1; step(1); periph_act = 1'b0;
        // R11 timeout registers
        wr(0, T_D); wr(1, T_S); wr(2, T_U); wr(3, T_H);
        wr(5, 31);
    endtask

    task automatic t_doze();
        pulse_sys();
        step(T_D);
        check("R2 still full", int'(pm_state), 0);
        step(1);
        check("R2 doze", int'(pm_state), 1);
        check("R2 bit0", int'(smi_status[0]), 1);
    endtask

    task automatic t_cascade();
        step(T_S);
        check("R3 still doze", int'(pm_state), 1);
        step(1);
        check("R3 stby", int'(pm_state), 2);
        check("R3 bit1", int'(smi_status[1]), 1);
        step(T_U);
        check("R3 still stby", int'(pm_state), 2);
        step(1);
        check("R3 susp", int'(pm_state), 3);
        check("R3 bit2", int'(smi_status[2]), 1);
    endtask

    task automatic t_wake();
        pulse_sys();
        check("R5 full", int'(pm_state), 0);
        check("R5 bit3", int'(smi_status[3]), 1);
    endtask

    task automatic t_w1c();
        check("R8 smi set", int'(smi_req), 1);
        wr(5, 1);
        check("R8 partial clear", int'(smi_status), 14);
        check("R8 smi still", int'(smi_req), 1);
        wr(5, 31);
        check("R8 all clear", int'(smi_status), 0);
        check("R8 smi low", int'(smi_req), 0);
    endtask

    task automatic t_reload();
        pulse_sys();
        for (int k = 0; k < 3; k++) begin
            step(T_D - 3);
            pulse_sys();
        end
        check("R4 full", int'(pm_state), 0);
        check("R4 no doze flag", int'(smi_status[0]), 0);
    endtask

    task automatic t_hk();
        // R6 housekeeping in full-on has no effect
        pulse_sys();
        step(5);
        pulse_hk();
        step(T_D - 6);
        check("R6 full", int'(pm_state), 0);
        step(1);
        check("R6 doze on time", int'(pm_state), 1);
        pulse_hk();
        step(T_S + T_H);
        check("R6 held in doze", int'(pm_state), 1);
        step(1);
        check("R6 stby after hold", int'(pm_state), 2);
        check("R6 no wake", int'(smi_status[3]), 0);
        pulse_sys();
        wr(5, 31);
    endtask

    task automatic t_periph();
        wr(4, 12);
        periph_act = 1'b1; step(1); periph_act = 1'b0;
        step(11);
        check("R7 not idle", int'(periph_idle), 0);
        step(1);
        check("R7 idle", int'(periph_idle), 1);
        check("R7 bit4 not yet", int'(smi_status[4]), 0);
        step(1);
        check("R7 bit4", int'(smi_status[4]), 1);
        wr(4, 60000);
        periph_act = 1'b1; step(1); periph_act = 1'b0;
        wr(5, 31);
    endtask

    task automatic t_duty();
        int hi;
        wr(0, 60000);
        pulse_sys();
        wr(6, (2 << 8) | 3);
        step(40);
        count_high(5 * DIVT, hi);
        check("R9 full duty 3/2", hi, 3 * DIVT);
        wr(6, 4);
        step(8);
        count_high(20, hi);
        check("R9 off zero high", hi, 20);
        wr(6, 3 << 8);
        step(8);
        count_high(20, hi);
        check("R9 on zero low", hi, 0);
        wr(6, 1);
        wr(9, (3 << 8) | 1);
        wr(0, T_D);
        pulse_sys();
        step(T_D + 1 + T_S + 1 + T_U + 1);
        check("R9 in susp", int'(pm_state), 3);
        step(30);
        count_high(4 * DIVT, hi);
        check("R9 susp duty 1/3", hi, DIVT);
    endtask

    task automatic t_plane();
        wr(10, 5);
        check("R10 susp mask", int'(plane_en), 10);
        pulse_sys();
        check("R10 full planes", int'(plane_en), 15);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_setup();
        t_doze();
        t_cascade();
        t_wake();
        t_w1c();
        t_reload();
        t_hk();
        t_periph();
        t_duty();
        t_plane();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule